// File: doc/BRIEF.md
# Dual Timeout Event Timer

This block measures two timeouts back to back from a single arming request. Time is counted in ticks of an external strobe, normally a one-millisecond pulse. An arm request clears the timer and starts the first stage. When the first stage has counted its limit of ticks, the block raises a one-cycle pulse. It then clears the count and runs the second stage. At the end of the second stage it raises a second one-cycle pulse and goes idle.

The strobe can also be the end-of-count pulse from a faster hardware timing unit. In that case a divide parameter sets how many raw pulses make one counted tick, so the block works as a prescaler.

A typical user is a supervisory controller. It arms the timer on some event, reacts to the first pulse (for example by starting a warning), and uses the second pulse to bound how long that reaction lasts. Arming again at any time restarts the whole sequence from zero.

Top module: `dual_timeout_timer`

## Requirements
- R1: After reset both done outputs are low and the timer is idle.
- R2: While idle, strobe pulses are ignored: no done pulse appears until an arm request is seen.
- R3: An arm request clears the count (and the prescale phase) and starts the first stage. `stage1_done` is high for the one cycle after the clock edge that samples the FIRST_TICKS-th counted tick.
- R4: After the first stage the count starts again from zero. `stage2_done` is high for the one cycle after the edge that samples the SECOND_TICKS-th counted tick of the second stage.
- R5: Each done output is high for exactly one cycle. After `stage2_done` the timer is idle, and further strobes give no pulse.
- R6: An arm request during either stage restarts from zero in the first stage, and ticks counted before it are dropped.
- R7: When an arm request and a strobe arrive in the same cycle, the arm request takes effect and that strobe is not counted.
- R8: With TICK_DIV = P, one counted tick takes P raw strobe pulses. The first stage therefore ends on raw pulse P*FIRST_TICKS and the second on raw pulse P*(FIRST_TICKS+SECOND_TICKS), both counted from the arm request.
- R9: Cycles with the strobe low do not advance the count, however many there are between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_strobe | input | 1 | Tick strobe, one cycle per tick (or raw pulse when prescaling) |
| arm_req | input | 1 | Clears the timer and starts the first stage |
| stage1_done | output | 1 | Registered one-cycle pulse at the end of the first stage |
| stage2_done | output | 1 | Registered one-cycle pulse at the end of the second stage |

## Verification
Both done pulses come from registers. Each one is due in the cycle that follows the clock edge that samples the final counted strobe, so the latency is one cycle. An arm request takes effect at the edge that samples it.

The bench drives its inputs on falling edges and reads the outputs at the next falling edge. That is the first point where the registered result of the sampled edge is visible. After each strobe it also checks the following cycle, to catch a pulse that lasts too long or arrives late.

A second instance with a divide of three checks the prescaled timing, counted in raw pulses.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } dtt_state_e;
endpackage

// File: rtl/dtt_prescale.sv
module dtt_prescale #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  input  logic raw_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      phase <= '0;
    end else if (raw_i && run_i) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  assign tick_o = raw_i && run_i && !clr_i && (phase == LAST);

  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);

  // R2
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |-> !tick_o);

  // R7
  arm_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |-> !tick_o);
endmodule

// File: rtl/dtt_stage_seq.sv
module dtt_stage_seq
  import dtt_pkg::*;
#(
  parameter int FIRST_TICKS  = 5,
  parameter int SECOND_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick_i,
  output logic armed_o,
  output logic end1_o,
  output logic end2_o
);
  localparam int MAXT = (FIRST_TICKS > SECOND_TICKS) ? FIRST_TICKS : SECOND_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LIM1 = CW'(FIRST_TICKS - 1);
  localparam logic [CW-1:0] LIM2 = CW'(SECOND_TICKS - 1);

  dtt_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      end1_o <= 1'b0;
      end2_o <= 1'b0;
    end else begin
      end1_o <= 1'b0;
      end2_o <= 1'b0;
      if (start_i) begin
        state <= ST_FIRST;
        cnt   <= '0;
      end else if (tick_i) begin
        case (state)
          ST_FIRST: begin
            if (cnt == LIM1) begin
              end1_o <= 1'b1;
              cnt    <= '0;
              state  <= ST_SECOND;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_SECOND: begin
            if (cnt == LIM2) begin
              end2_o <= 1'b1;
              cnt    <= '0;
              state  <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign armed_o = (state != ST_IDLE);

  // R3
  start_arms_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (state == ST_FIRST && cnt == '0 && !end1_o && !end2_o));

  // R5
  end1_width_chk: assert property (@(posedge clk) disable iff (rst)
    end1_o |=> !end1_o);

  // R5
  end2_width_chk: assert property (@(posedge clk) disable iff (rst)
    end2_o |=> !end2_o);

  // R4
  end2_source_chk: assert property (@(posedge clk) disable iff (rst)
    end2_o |-> (state == ST_IDLE && $past(state) == ST_SECOND));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start_i) |=> (state == ST_IDLE && !end1_o && !end2_o));

  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !start_i) |=> $stable(cnt));

  // R3
  first_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIRST) |-> (cnt <= LIM1));
endmodule

// File: rtl/dual_timeout_timer.sv
module dual_timeout_timer #(
  parameter int FIRST_TICKS  = 5,
  parameter int SECOND_TICKS = 10,
  parameter int TICK_DIV     = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_strobe,
  input  logic arm_req,
  output logic stage1_done,
  output logic stage2_done
);
  logic armed;
  logic tick;

  dtt_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (arm_req),
    .run_i  (armed),
    .raw_i  (ms_strobe),
    .tick_o (tick)
  );

  dtt_stage_seq #(
    .FIRST_TICKS  (FIRST_TICKS),
    .SECOND_TICKS (SECOND_TICKS)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (arm_req),
    .tick_i  (tick),
    .armed_o (armed),
    .end1_o  (stage1_done),
    .end2_o  (stage2_done)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!stage1_done && !stage2_done));

  // R5
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(stage1_done && stage2_done));
endmodule

// File: tb/dual_timeout_timer_tb_top.sv
module dual_timeout_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L1 = 5;
  localparam int L2 = 10;
  localparam int PL1 = 2;
  localparam int PL2 = 3;
  localparam int PDIV = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic arm = 1'b0;
  logic d1, d2, p1, p2;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_timeout_timer #(.FIRST_TICKS(L1), .SECOND_TICKS(L2), .TICK_DIV(1)) dut_i (
    .clk(clk), .rst(rst), .ms_strobe(strobe), .arm_req(arm),
    .stage1_done(d1), .stage2_done(d2));

  dual_timeout_timer #(.FIRST_TICKS(PL1), .SECOND_TICKS(PL2), .TICK_DIV(PDIV)) dut_p (
    .clk(clk), .rst(rst), .ms_strobe(strobe), .arm_req(arm),
    .stage1_done(p1), .stage2_done(p2));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, then move to the next falling edge,
  // where the registered result of the rising edge in between is visible.
  task automatic cyc(input logic s, input logic a);
    strobe = s;
    arm = a;
    @(negedge clk);
    strobe = 1'b0;
    arm = 1'b0;
  endtask

  // One strobe plus gap cycles; returns the outputs seen right after the strobe.
  task automatic tick(input int gap, output logic o1, output logic o2,
                      output logic q1, output logic q2);
    cyc(1'b1, 1'b0);
    o1 = d1; o2 = d2; q1 = p1; q2 = p2;
    for (int g = 0; g < gap; g++) begin
      cyc(1'b0, 1'b0);
      if (g == 0) begin
        if (o1) chk("R5 stage1 width", d1, 1'b0);
        if (o2) chk("R5 stage2 width", d2, 1'b0);
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 stage1 low after reset", d1, 1'b0);
    chk("R1 stage2 low after reset", d2, 1'b0);
  endtask

  task automatic t_idle();
    int seen = 0;
    logic a, b, c, e;
    for (int i = 0; i < 2 * (L1 + L2); i++) begin
      tick(0, a, b, c, e);
      if (a || b || c || e) seen++;
    end
    chk("R2 idle strobes ignored", seen != 0, 1'b0);
  endtask

  task automatic t_full();
    logic a, b, c, e;
    cyc(1'b0, 1'b1);
    for (int i = 1; i <= L1 + L2; i++) begin
      tick((i % 3) + 1, a, b, c, e);
      chk("R3/R9 stage1 timing", a, i == L1);
      chk("R4/R9 stage2 timing", b, i == L1 + L2);
    end
  endtask

  task automatic t_after_end();
    int seen = 0;
    logic a, b, c, e;
    for (int i = 0; i < L1 + L2 + 2; i++) begin
      tick(0, a, b, c, e);
      if (a || b) seen++;
    end
    chk("R5 idle after stage2", seen != 0, 1'b0);
  endtask

  task automatic t_restart_first();
    logic a, b, c, e;
    cyc(1'b0, 1'b1);
    for (int i = 0; i < L1 - 2; i++) tick(0, a, b, c, e);
    cyc(1'b0, 1'b1);
    for (int i = 1; i <= L1; i++) begin
      tick(1, a, b, c, e);
      chk("R6 restart in stage1", a, i == L1);
    end
  endtask

  task automatic t_restart_second();
    logic a, b, c, e;
    for (int i = 0; i < L2 - 2; i++) tick(0, a, b, c, e);
    chk("R6 still in stage2", b, 1'b0);
    cyc(1'b0, 1'b1);
    for (int i = 1; i <= L1; i++) begin
      tick(0, a, b, c, e);
      chk("R6 restart in stage2", a, i == L1);
      chk("R6 no stage2 after restart", b, 1'b0);
    end
  endtask

  task automatic t_same_cycle();
    logic a, b, c, e;
    cyc(1'b1, 1'b1);
    chk("R7 no pulse on arm", d1, 1'b0);
    for (int i = 1; i <= L1; i++) begin
      tick(0, a, b, c, e);
      chk("R7 strobe with arm not counted", a, i == L1);
    end
  endtask

  task automatic t_prescale();
    logic a, b, c, e;
    cyc(1'b0, 1'b1);
    for (int i = 1; i <= PDIV * (PL1 + PL2); i++) begin
      tick(1, a, b, c, e);
      chk("R8 prescaled stage1", c, i == PDIV * PL1);
      chk("R8 prescaled stage2", e, i == PDIV * (PL1 + PL2));
    end
    cyc(1'b0, 1'b1);
    for (int i = 0; i < PDIV - 1; i++) tick(0, a, b, c, e);
    cyc(1'b0, 1'b1);
    for (int i = 1; i <= PDIV * PL1; i++) begin
      tick(0, a, b, c, e);
      chk("R8 phase cleared by arm", c, i == PDIV * PL1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_full();
    t_after_end();
    t_restart_first();
    t_restart_second();
    t_same_cycle();
    t_prescale();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule